// File: doc/BRIEF.md
# Link Control and Status Register Block

This block holds the capability, control and status registers of one serial-link port. Software reaches it over a simple word-wide register bus with an address, four byte enables, write data and registered read data. On the other side it watches the current state of the link training state machine and the negotiated width and speed. It drives that machine with a one-cycle retrain request and a set of control fields: power-management enable, extended synchronisation, target speed, transmit margin and compliance entry.

The four registers mix several access behaviours. Some capability fields take a single write after reset and then lock. The retrain command clears itself. The training indicator is tracked by hardware. The equalization request flag is cleared by writing one to it. The second control register is sticky: it survives a warm reset, and only a cold reset returns it to its defaults. Word 0 (byte 0x0) holds the link base address in bits 31:12. Word 1 (0x4) holds capabilities. Word 2 (0x8) has control in bits 15:0 and status in bits 31:16. Word 3 (0xC) has sticky control in bits 15:0 and status in bits 31:16.

Top module: `lnk_csr_top`

## Requirements
- R1: After a cold reset the four words read 0x0000_0000, 0x0041_AC42, 0x0001_0000 (state Detect, negotiated speed input 1) and 0x0000_0001. Word 1 packs max speed in [3:0], max width in [9:4], 2'b11 in [11:10], L0s exit latency in [14:12] (reset 2), L1 exit latency in [17:15] (reset 3) and a constant 1 in [22].
- R2: Read data appears in the cycle after the read request and is zero in any cycle that follows no read. Reads change no bit.
- R3: The link base address (word 0, bits 31:12) takes the first write after reset that enables bytes 1, 2 and 3 together, and then locks. A write that leaves out any of those bytes changes nothing and does not lock.
- R4: The exit-latency pair (word 1, bits 17:12) is write-once. It locks only on a write that enables bytes 1 and 2 together.
- R5: Writing 1 to word 2 bit 5 with byte 0 enabled makes retrain_req high for exactly the following cycle. That bit always reads 0.
- R6: The training bit (word 2 bit 27) is 1 from the cycle after a retrain write until the state machine reaches Configuration or Recovery. It is also 1 while the state machine is in either of those states, and 0 once it has left them.
- R7: Word 2 bits 19:16 report the negotiated speed input. Bits 25:20 report the negotiated width (01h/02h/04h) only in L0, L0s or L1 and read 0 otherwise. The state encoding is Detect=0, PollActive=1, PollConfig=2, Config=3, L0=4, L0s=5, L1=6, Recovery=7.
- R8: Word 2 bits 1:0 (power management: 00 off, 01 L0s, 10 L1, 11 both) and bit 7 (extended sync) are read/write and drive aspm_ctl and ext_sync. Reserved bits read 0 whatever is written.
- R9: The equalization request (word 3 bit 21) sets on an eq_req_set pulse and clears only when 1 is written to it with byte 2 enabled. Writing 0 has no effect.
- R10: The transmit margin (word 3 bits 9:7) clears to 0 in the cycle the state machine enters PollConfig. Writes made while it stays in PollConfig take effect.
- R11: The target speed (word 3 bits 3:0, 1 = 2.5 GT/s, 2 = 5.0 GT/s) resets to 1 and accepts only values from 1 to the maximum speed. Any other written value leaves it unchanged.
- R12: A warm reset keeps word 3 bits 15:0, the write-once values and their locks. It clears power management, extended sync, the equalization request and any pending training indication.
- R13: A cold reset returns every field to its default and unlocks the write-once fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_cold_n | input | 1 | Power-on reset, active low, clears everything |
| rst_warm_n | input | 1 | Warm reset, active low, spares sticky and write-once state |
| bus_wr | input | 1 | Write request |
| bus_rd | input | 1 | Read request |
| bus_addr | input | ADDR_W | Byte address; bits 3:2 select the word, higher bits must be 0 |
| bus_be | input | 4 | Byte enables |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| lts_state | input | 3 | Training state machine state |
| neg_width | input | 6 | Negotiated lane count |
| neg_speed | input | 4 | Negotiated speed code |
| eq_req_set | input | 1 | Hardware request for equalization |
| retrain_req | output | 1 | One-cycle retrain command |
| aspm_ctl | output | 2 | Power-management enable |
| ext_sync | output | 1 | Extended synchronisation enable |
| tgt_speed | output | 4 | Target link speed |
| tx_margin | output | 3 | Transmit margin setting |
| enter_comp | output | 1 | Compliance entry request |

## Verification
The bench targets byte-enable partial writes to the write-once fields. A design that locked on a partial write would freeze a half-written address or latency and refuse the later full write. It also drives a retrain with the link up, then moves the state machine through Recovery. This exposes a training bit that never sets, or one that sticks after training has ended. Other cases are an illegal target-speed write, which a naive design would store, and a margin write made while the state machine stays in PollConfig, which an over-eager clear would wipe. A warm reset after every field has been loaded shows whether sticky and write-once state was wrongly cleared, or non-sticky state wrongly kept.

// File: rtl/lnk_csr_pkg.sv
`timescale 1ns/1ps
package lnk_csr_pkg;

   typedef enum logic [2:0] {
      ST_DETECT   = 3'd0,
      ST_POLL_ACT = 3'd1,
      ST_POLL_CFG = 3'd2,
      ST_CONFIG   = 3'd3,
      ST_L0       = 3'd4,
      ST_L0S      = 3'd5,
      ST_L1       = 3'd6,
      ST_RECOVERY = 3'd7
   } lts_state_e;

   localparam logic [1:0] WORD_BASE = 2'd0;
   localparam logic [1:0] WORD_CAP  = 2'd1;
   localparam logic [1:0] WORD_CTL  = 2'd2;
   localparam logic [1:0] WORD_CTL2 = 2'd3;

   // expand four byte enables into a 32-bit bit mask
   function automatic logic [31:0] be_to_mask(input logic [3:0] be);
      logic [31:0] m;
      for (int b = 0; b < 4; b++) m[b*8 +: 8] = {8{be[b]}};
      return m;
   endfunction

   function automatic logic link_up(input lts_state_e s);
      return (s == ST_L0) || (s == ST_L0S) || (s == ST_L1);
   endfunction

endpackage

// File: rtl/lnk_csr_wonce.sv
`timescale 1ns/1ps
module lnk_csr_wonce #(
   parameter int          W   = 8,
   parameter logic [W-1:0] RST = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] val,
   output logic         locked
);

   if (W < 1) begin : g_bad_w
      $error("lnk_csr_wonce: W must be positive");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         val    <= RST;
         locked <= 1'b0;
      end else if (wr_en && !locked) begin
         val    <= wdata;
         locked <= 1'b1;
      end
   end

   // R3 and R4: once locked the value never moves until cold reset
   a_r3_locked_stable : assert property (@(posedge clk) disable iff (!rst_n)
      locked |=> $stable(val));

endmodule

// File: rtl/lnk_csr_train.sv
`timescale 1ns/1ps
module lnk_csr_train
   import lnk_csr_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       retrain_wr,
   input  lts_state_e st,
   output logic       retrain_req,
   output logic       train_status
);

   logic pend_q;
   logic in_cr;

   assign in_cr = (st == ST_CONFIG) || (st == ST_RECOVERY);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         retrain_req <= 1'b0;
         pend_q      <= 1'b0;
      end else begin
         retrain_req <= retrain_wr;
         if (retrain_wr)  pend_q <= 1'b1;
         else if (in_cr)  pend_q <= 1'b0;
      end
   end

   assign train_status = pend_q | in_cr;

   // R6: a request on the wire always coincides with training shown
   a_r6_req_shows_training : assert property (@(posedge clk) disable iff (!rst_n)
      retrain_req |-> train_status);

endmodule

// File: rtl/lnk_csr_ctl2.sv
`timescale 1ns/1ps
module lnk_csr_ctl2
   import lnk_csr_pkg::*;
#(
   parameter int MAX_SPEED = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [1:0]  be,
   input  logic [15:0] wdata,
   input  lts_state_e  st,
   output logic [15:0] ctl2
);

   localparam logic [15:0] WMASK = 16'hFFBF;
   localparam logic [15:0] RSTV  = 16'h0001;
   localparam logic [3:0]  MS    = 4'(MAX_SPEED);

   lts_state_e  prev_q;
   logic        entry;
   logic [15:0] m;
   logic [15:0] merged;
   logic [3:0]  tgt_sel;
   logic [15:0] nxt;
   logic [31:0] bm;

   assign bm     = be_to_mask({2'b00, be});
   assign m      = wr_en ? (bm[15:0] & WMASK) : 16'h0000;
   assign merged = (ctl2 & ~m) | (wdata & m);
   assign entry  = (st == ST_POLL_CFG) && (prev_q != ST_POLL_CFG);

   if (MAX_SPEED == 1) begin : g_spd_fixed
      assign tgt_sel = 4'd1;
   end else begin : g_spd_sel
      assign tgt_sel = ((merged[3:0] >= 4'd1) && (merged[3:0] <= MS)) ?
                       merged[3:0] : ctl2[3:0];
   end

   always_comb begin
      nxt      = merged;
      nxt[3:0] = tgt_sel;
      if (entry) nxt[9:7] = 3'b000;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl2   <= RSTV;
         prev_q <= ST_DETECT;
      end else begin
         prev_q <= st;
         if (wr_en || entry) ctl2 <= nxt;
      end
   end

   // R10: entering PollConfig leaves margin zero
   a_r10_margin_cleared : assert property (@(posedge clk) disable iff (!rst_n)
      entry |=> (ctl2[9:7] == 3'b000));

   // R11: target speed never holds an unsupported code
   a_r11_tgt_legal : assert property (@(posedge clk) disable iff (!rst_n)
      (ctl2[3:0] >= 4'd1) && (ctl2[3:0] <= MS));

endmodule

// File: rtl/lnk_csr_top.sv
`timescale 1ns/1ps
module lnk_csr_top
   import lnk_csr_pkg::*;
#(
   parameter int ADDR_W      = 8,
   parameter int MAX_WIDTH   = 4,
   parameter int MAX_SPEED   = 2,
   parameter int L0S_LAT_RST = 2,
   parameter int L1_LAT_RST  = 3
) (
   input  logic              clk,
   input  logic              rst_cold_n,
   input  logic              rst_warm_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [3:0]        bus_be,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic [2:0]        lts_state,
   input  logic [5:0]        neg_width,
   input  logic [3:0]        neg_speed,
   input  logic              eq_req_set,
   output logic              retrain_req,
   output logic [1:0]        aspm_ctl,
   output logic              ext_sync,
   output logic [3:0]        tgt_speed,
   output logic [2:0]        tx_margin,
   output logic              enter_comp
);

   localparam logic [5:0] MW      = 6'(MAX_WIDTH);
   localparam logic [3:0] MS      = 4'(MAX_SPEED);
   localparam logic [5:0] LAT_RST = {3'(L1_LAT_RST), 3'(L0S_LAT_RST)};
   localparam int         NWORDS  = 4;

   if (ADDR_W < 5) begin : g_bad_addr
      $error("lnk_csr_top: ADDR_W must be at least 5");
   end
   if (!(MAX_WIDTH == 1 || MAX_WIDTH == 2 || MAX_WIDTH == 4)) begin : g_bad_width
      $error("lnk_csr_top: MAX_WIDTH must be 1, 2 or 4");
   end
   if (MAX_SPEED < 1 || MAX_SPEED > 2) begin : g_bad_speed
      $error("lnk_csr_top: MAX_SPEED must be 1 or 2");
   end
   if (L0S_LAT_RST < 0 || L0S_LAT_RST > 7 || L1_LAT_RST < 0 || L1_LAT_RST > 7) begin : g_bad_lat
      $error("lnk_csr_top: latency defaults must fit in 3 bits");
   end

   logic              rst_any_n;
   lts_state_e        st;
   logic              in_range;
   logic [1:0]        word;
   logic [NWORDS-1:0] wr_w;
   logic [19:0]       base_val;
   logic              base_lock;
   logic [5:0]        lat_val;
   logic              lat_lock;
   logic              retrain_wr;
   logic              train_status;
   logic [15:0]       ctl2;
   logic              eq_q;
   logic [5:0]        width_rd;
   logic [31:0]       rd_mux [NWORDS];
   logic              unused_bits;

   assign rst_any_n = rst_cold_n & rst_warm_n;
   assign st        = lts_state_e'(lts_state);
   assign in_range  = (bus_addr[ADDR_W-1:4] == '0);
   assign word      = bus_addr[3:2];

   for (genvar i = 0; i < NWORDS; i++) begin : g_wsel
      assign wr_w[i] = bus_wr && in_range && (word == 2'(i));
   end

   lnk_csr_wonce #(.W(20), .RST(20'h0)) u_base (
      .clk    (clk),
      .rst_n  (rst_cold_n),
      .wr_en  (wr_w[WORD_BASE] && (&bus_be[3:1])),
      .wdata  (bus_wdata[31:12]),
      .val    (base_val),
      .locked (base_lock)
   );

   lnk_csr_wonce #(.W(6), .RST(LAT_RST)) u_lat (
      .clk    (clk),
      .rst_n  (rst_cold_n),
      .wr_en  (wr_w[WORD_CAP] && bus_be[1] && bus_be[2]),
      .wdata  (bus_wdata[17:12]),
      .val    (lat_val),
      .locked (lat_lock)
   );

   assign retrain_wr = wr_w[WORD_CTL] && bus_be[0] && bus_wdata[5];

   lnk_csr_train u_train (
      .clk          (clk),
      .rst_n        (rst_any_n),
      .retrain_wr   (retrain_wr),
      .st           (st),
      .retrain_req  (retrain_req),
      .train_status (train_status)
   );

   lnk_csr_ctl2 #(.MAX_SPEED(MAX_SPEED)) u_ctl2 (
      .clk   (clk),
      .rst_n (rst_cold_n),
      .wr_en (wr_w[WORD_CTL2]),
      .be    (bus_be[1:0]),
      .wdata (bus_wdata[15:0]),
      .st    (st),
      .ctl2  (ctl2)
   );

   // non-sticky control and the write-one-to-clear request
   always_ff @(posedge clk or negedge rst_any_n) begin
      if (!rst_any_n) begin
         aspm_ctl <= 2'b00;
         ext_sync <= 1'b0;
         eq_q     <= 1'b0;
      end else begin
         if (wr_w[WORD_CTL] && bus_be[0]) begin
            aspm_ctl <= bus_wdata[1:0];
            ext_sync <= bus_wdata[7];
         end
         if (eq_req_set)
            eq_q <= 1'b1;
         else if (wr_w[WORD_CTL2] && bus_be[2] && bus_wdata[21])
            eq_q <= 1'b0;
      end
   end

   assign width_rd = link_up(st) ? neg_width : 6'h00;

   assign rd_mux[0] = {base_val, 12'h000};
   assign rd_mux[1] = {9'h000, 1'b1, 4'h0, lat_val, 2'b11, MW, MS};
   assign rd_mux[2] = {4'h0, train_status, 1'b0, width_rd, neg_speed,
                       8'h00, ext_sync, 1'b0, 1'b0, 3'b000, aspm_ctl};
   assign rd_mux[3] = {10'h000, eq_q, 5'h00, ctl2};

   always_ff @(posedge clk or negedge rst_any_n) begin
      if (!rst_any_n)               bus_rdata <= 32'h0;
      else if (bus_rd && in_range)  bus_rdata <= rd_mux[word];
      else                          bus_rdata <= 32'h0;
   end

   assign tgt_speed  = ctl2[3:0];
   assign tx_margin  = ctl2[9:7];
   assign enter_comp = ctl2[4];
   assign unused_bits = ^{bus_addr[1:0], base_lock, lat_lock};

   // R5: a retrain request only follows a bus write
   a_r5_req_after_write : assert property (@(posedge clk) disable iff (!rst_any_n)
      retrain_req |-> $past(bus_wr));

   // R9: a hardware request is always captured
   a_r9_set_captured : assert property (@(posedge clk) disable iff (!rst_any_n)
      eq_req_set |=> eq_q);

   // R9: the flag never rises without a hardware request
   a_r9_no_spurious : assert property (@(posedge clk) disable iff (!rst_any_n)
      $rose(eq_q) |-> $past(eq_req_set));

   // R2: nothing is returned in a cycle that follows no read
   a_r2_idle_zero : assert property (@(posedge clk) disable iff (!rst_any_n)
      !bus_rd |=> (bus_rdata == 32'h0));

endmodule

// File: tb/test_lnk_csr_top.sv
`timescale 1ns/1ps
module test_lnk_csr_top;

   logic        clk = 1'b0;
   logic        rst_cold_n, rst_warm_n;
   logic        bus_wr, bus_rd;
   logic [7:0]  bus_addr;
   logic [3:0]  bus_be;
   logic [31:0] bus_wdata, bus_rdata;
   logic [2:0]  lts_state;
   logic [5:0]  neg_width;
   logic [3:0]  neg_speed;
   logic        eq_req_set, retrain_req, ext_sync, enter_comp;
   logic [1:0]  aspm_ctl;
   logic [3:0]  tgt_speed;
   logic [2:0]  tx_margin;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   localparam logic [2:0] S_DET = 3'd0, S_PCFG = 3'd2, S_CFG = 3'd3,
                          S_L0 = 3'd4, S_L1 = 3'd6, S_REC = 3'd7;

   always #2 clk = ~clk;   // 4 ns period

   lnk_csr_top i_lnk_csr_top (
      .clk(clk), .rst_cold_n(rst_cold_n), .rst_warm_n(rst_warm_n),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_be(bus_be),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .lts_state(lts_state),
      .neg_width(neg_width), .neg_speed(neg_speed), .eq_req_set(eq_req_set),
      .retrain_req(retrain_req), .aspm_ctl(aspm_ctl), .ext_sync(ext_sync),
      .tgt_speed(tgt_speed), .tx_margin(tx_margin), .enter_comp(enter_comp)
   );

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %08h expected %08h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0; bus_be = 4'h0; bus_wdata = 32'h0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
      logic [31:0] d;
      rd(a, d);
      chk(tag, d, exp);
   endtask

   task automatic set_link(input logic [2:0] s, input logic [5:0] w, input logic [3:0] sp);
      @(negedge clk);
      lts_state = s; neg_width = w; neg_speed = sp;
   endtask

   task automatic t_reset_values;
      rd_chk("R1 word0", 8'h0, 32'h0000_0000);
      rd_chk("R1 word1", 8'h4, 32'h0041_AC42);
      rd_chk("R1 word2", 8'h8, 32'h0001_0000);
      rd_chk("R1 word3", 8'hC, 32'h0000_0001);
      chk("R1 tgt_speed port", {28'h0, tgt_speed}, 32'h1);
   endtask

   task automatic t_read_latency;
      rd_chk("R2 read data", 8'h4, 32'h0041_AC42);
      @(negedge clk);
      chk("R2 idle zero", bus_rdata, 32'h0);
   endtask

   task automatic t_base_once;
      wr(8'h0, 4'b0110, 32'hABCD_E000);
      rd_chk("R3 partial ignored", 8'h0, 32'h0);
      wr(8'h0, 4'b1111, 32'h1234_5FFF);
      rd_chk("R3 first full write", 8'h0, 32'h1234_5000);
      wr(8'h0, 4'b1111, 32'hFFFF_F000);
      rd_chk("R3 locked", 8'h0, 32'h1234_5000);
   endtask

   task automatic t_lat_once;
      wr(8'h4, 4'b0010, 32'h0000_5000);
      rd_chk("R4 partial ignored", 8'h4, 32'h0041_AC42);
      wr(8'h4, 4'b0110, 32'h0003_1000);
      rd_chk("R4 full write", 8'h4, 32'h0043_1C42);
      wr(8'h4, 4'b1111, 32'h0000_F000);
      rd_chk("R4 locked", 8'h4, 32'h0043_1C42);
   endtask

   task automatic t_retrain;
      set_link(S_L0, 6'h04, 4'h2);
      chk("R5 idle req", {31'h0, retrain_req}, 32'h0);
      wr(8'h8, 4'b0001, 32'h0000_0020);
      chk("R5 req high", {31'h0, retrain_req}, 32'h1);
      @(negedge clk);
      chk("R5 req one cycle", {31'h0, retrain_req}, 32'h0);
      rd_chk("R5 R6 bit reads 0, training set", 8'h8, 32'h0842_0000);
   endtask

   task automatic t_training;
      set_link(S_REC, 6'h04, 4'h2);
      rd_chk("R6 R7 recovery, width hidden", 8'h8, 32'h0802_0000);
      set_link(S_L0, 6'h04, 4'h2);
      rd_chk("R6 cleared after training", 8'h8, 32'h0042_0000);
      set_link(S_CFG, 6'h01, 4'h1);
      rd_chk("R6 config shows training", 8'h8, 32'h0801_0000);
   endtask

   task automatic t_negotiated;
      set_link(S_L1, 6'h02, 4'h1);
      rd_chk("R7 L1 width x2", 8'h8, 32'h0021_0000);
      set_link(S_DET, 6'h02, 4'h1);
      rd_chk("R7 width hidden when down", 8'h8, 32'h0001_0000);
   endtask

   task automatic t_aspm;
      wr(8'h8, 4'b1111, 32'hFFFF_FFDF);
      rd_chk("R8 control and reserved", 8'h8, 32'h0001_0083);
      chk("R8 aspm port both", {30'h0, aspm_ctl}, 32'h3);
      chk("R8 ext_sync port", {31'h0, ext_sync}, 32'h1);
      chk("R5 no req without bit", {31'h0, retrain_req}, 32'h0);
      wr(8'h8, 4'b0001, 32'h0000_0001);
      chk("R8 aspm L0s only", {30'h0, aspm_ctl}, 32'h1);
      chk("R8 ext_sync cleared", {31'h0, ext_sync}, 32'h0);
   endtask

   task automatic t_eq;
      @(negedge clk); eq_req_set = 1'b1;
      @(negedge clk); eq_req_set = 1'b0;
      rd_chk("R9 set by hardware", 8'hC, 32'h0020_0001);
      rd_chk("R2 R9 read no side effect", 8'hC, 32'h0020_0001);
      wr(8'hC, 4'b0100, 32'h0000_0000);
      rd_chk("R9 write 0 ignored", 8'hC, 32'h0020_0001);
      wr(8'hC, 4'b0100, 32'h0020_0000);
      rd_chk("R9 write 1 clears", 8'hC, 32'h0000_0001);
   endtask

   task automatic t_margin;
      wr(8'hC, 4'b0011, 32'h0000_02C2);
      rd_chk("R10 R11 margin and speed, reserved bit6", 8'hC, 32'h0000_0282);
      chk("R10 tx_margin port", {29'h0, tx_margin}, 32'h5);
      set_link(S_PCFG, 6'h00, 4'h1);
      @(negedge clk);
      chk("R10 cleared on entry", {29'h0, tx_margin}, 32'h0);
      wr(8'hC, 4'b0011, 32'h0000_0182);
      rd_chk("R10 write while staying", 8'hC, 32'h0000_0182);
      set_link(S_DET, 6'h00, 4'h1);
   endtask

   task automatic t_tgt;
      wr(8'hC, 4'b0011, 32'h0000_0183);
      rd_chk("R11 unsupported 3 ignored", 8'hC, 32'h0000_0182);
      wr(8'hC, 4'b0011, 32'h0000_0180);
      rd_chk("R11 zero ignored", 8'hC, 32'h0000_0182);
      wr(8'hC, 4'b0011, 32'h0000_0181);
      chk("R11 back to 2.5", {28'h0, tgt_speed}, 32'h1);
   endtask

   task automatic t_warm;
      wr(8'hC, 4'b0011, 32'h0000_A192);
      @(negedge clk); eq_req_set = 1'b1;
      @(negedge clk); eq_req_set = 1'b0;
      wr(8'h8, 4'b0001, 32'h0000_0023);
      @(negedge clk); rst_warm_n = 1'b0;
      @(negedge clk); rst_warm_n = 1'b1;
      rd_chk("R12 sticky kept, eq cleared", 8'hC, 32'h0000_A192);
      chk("R12 enter_comp kept", {31'h0, enter_comp}, 32'h1);
      rd_chk("R12 base kept", 8'h0, 32'h1234_5000);
      rd_chk("R12 latency kept", 8'h4, 32'h0043_1C42);
      wr(8'h4, 4'b0110, 32'h0000_0000);
      rd_chk("R12 lock kept", 8'h4, 32'h0043_1C42);
      set_link(S_L0, 6'h04, 4'h2);
      rd_chk("R12 aspm and training cleared", 8'h8, 32'h0042_0000);
   endtask

   task automatic t_cold;
      set_link(S_DET, 6'h00, 4'h1);
      @(negedge clk); rst_cold_n = 1'b0;
      @(negedge clk); rst_cold_n = 1'b1;
      rd_chk("R13 base default", 8'h0, 32'h0);
      rd_chk("R13 cap default", 8'h4, 32'h0041_AC42);
      rd_chk("R13 ctl2 default", 8'hC, 32'h0000_0001);
      wr(8'h0, 4'b1110, 32'h0F0F_0000);
      rd_chk("R13 base unlocked", 8'h0, 32'h0F0F_0000);
   endtask

   initial begin
      rst_cold_n = 1'b0; rst_warm_n = 1'b0;
      bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = 8'h0; bus_be = 4'h0; bus_wdata = 32'h0;
      lts_state = S_DET; neg_width = 6'h0; neg_speed = 4'h1; eq_req_set = 1'b0;
      repeat (3) @(negedge clk);
      rst_cold_n = 1'b1; rst_warm_n = 1'b1;
      t_reset_values();
      t_read_latency();
      t_base_once();
      t_lat_once();
      t_retrain();
      t_training();
      t_negotiated();
      t_aspm();
      t_eq();
      t_margin();
      t_tgt();
      t_warm();
      t_cold();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule